// File: doc/BRIEF.md
# Bridge Power Mode Controller

This block decides the power state of a host-to-PCI bridge with an integrated memory controller, and drives one registered enable line for each functional unit. Software picks a low-power level by writing a two-bit mode code with a write strobe. A dedicated input forces the deepest level, called suspend. A hard reset always brings the bridge back to full power.

In the light doze level, three units stay alive: PCI address decode, memory refresh and processor bus-request monitoring. A PCI hit on system memory or a processor bus request then starts a temporary serviced wake. This wake turns every unit back on and waits for the access-done pulse. It then falls back to the programmed low-power level without any software action. Gating only removes enables. The state held inside the gated units is never reset by it.

The current state is always readable on a three-bit status output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: On assertion of `rst_ni` (asynchronous, active low), the status reads full-on (code 0), every enable bit is 1 and the stored mode code is full-on. Status codes are: 0 full-on, 1 doze, 2 nap, 3 sleep, 4 suspend, 5 serviced wake. No other code ever appears.
- R2: Mode codes on `mode_i` are: 0 full-on, 1 doze, 2 nap, 3 sleep. A code is stored on a clock edge where `mode_we_i` is 1. From full-on, nap or sleep, the status moves to the stored level on the following edge.
- R3: In full-on and in serviced wake, every bit of `unit_en_o` is 1.
- R4: In doze, `unit_en_o` has only bit 0 (PCI address decode), bit 1 (refresh) and bit 2 (bus-request monitor) set.
- R5: In nap, only bits 1 and 2 are set. In sleep and in suspend, only bit 1 is set. Bit 1 (refresh) is never 0.
- R6: In doze, with `suspend_i` low, a 1 on `pci_mem_hit_i` or on `bus_req_i` moves the status to serviced wake on the next edge.
- R7: In serviced wake, an `access_done_i` pulse returns the status on the next edge to the stored low-power level. This needs no register write.
- R8: A low-power code written during serviced wake does not end the wake. It takes effect when access done arrives. A full-on code written during serviced wake moves the status to full-on on the edge after the write, and the block stays there.
- R9: A 1 on `suspend_i` moves any state to suspend on the next edge. When `suspend_i` returns to 0, the state held before suspend comes back on the next edge.
- R10: `suspend_i` takes priority over wake events, access done and mode changes. While it stays 1, the status stays at suspend.
- R11: In nap and sleep, `pci_mem_hit_i` and `bus_req_i` are ignored, and the status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 2 | Requested mode code |
| suspend_i | input | 1 | External suspend request |
| pci_mem_hit_i | input | 1 | PCI transaction targets system memory |
| bus_req_i | input | 1 | Processor bus request |
| access_done_i | input | 1 | The access being serviced has finished |
| unit_en_o | output | N_UNITS | Registered per-unit enables |
| state_o | output | 3 | Current power state code |

## Verification
Wakes are raised by a PCI hit and, separately, by a bus request. This shows both doze wake sources are decoded, and the same two inputs applied in nap and sleep show they are ignored there. A wake that ends with access done is compared against one that ends with a full-on write, and against one with a nap write left pending. Together these separate the automatic return path from the deferred and the immediate register effects. Suspend is entered from full-on and from doze, with wake events held high during it, to check both its priority and the restore of the prior state. An asynchronous reset taken in the middle of doze confirms that the mode field is cleared.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_FULL  = 3'd0,
    PS_DOZE  = 3'd1,
    PS_NAP   = 3'd2,
    PS_SLEEP = 3'd3,
    PS_SUSP  = 3'd4,
    PS_WAKE  = 3'd5
  } pwr_state_e;

  localparam int unsigned MODE_W        = 2;
  localparam int unsigned UNIT_PCI_DEC  = 0;
  localparam int unsigned UNIT_REFRESH  = 1;
  localparam int unsigned UNIT_BREQ_MON = 2;

  function automatic pwr_state_e code2state(input logic [MODE_W-1:0] code);
    case (code)
      2'd1:    return PS_DOZE;
      2'd2:    return PS_NAP;
      2'd3:    return PS_SLEEP;
      default: return PS_FULL;
    endcase
  endfunction
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q_o <= '0;
    else if (we_i) mode_q_o <= mode_i;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_q_i,
  input  logic              suspend_i,
  input  logic              pci_mem_hit_i,
  input  logic              bus_req_i,
  input  logic              access_done_i,
  output pwr_state_e        state_q_o,
  output pwr_state_e        state_d_o
);
  pwr_state_e state_q, state_d, saved_q, req_st;

  always_comb begin
    req_st  = code2state(mode_q_i);
    state_d = state_q;
    if (state_q == PS_SUSP) begin
      if (!suspend_i) state_d = saved_q;
    end else if (suspend_i) begin
      state_d = PS_SUSP;
    end else if (state_q == PS_DOZE) begin
      if (pci_mem_hit_i || bus_req_i) state_d = PS_WAKE;
      else if (req_st != PS_DOZE)     state_d = req_st;
    end else if (state_q == PS_WAKE) begin
      // full-on write exits at once; low-power writes wait for the access
      if (req_st == PS_FULL)  state_d = PS_FULL;
      else if (access_done_i) state_d = req_st;
    end else if (req_st != state_q) begin
      state_d = req_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_FULL;
      saved_q <= PS_FULL;
    end else begin
      state_q <= state_d;
      if (state_q != PS_SUSP && suspend_i) saved_q <= state_q;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/pwr_en_decode.sv
module pwr_en_decode
  import pwr_pkg::*;
#(
  parameter int unsigned N_UNITS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pwr_state_e         state_d_i,
  output logic [N_UNITS-1:0] unit_en_o
);
  logic all_on, doze, nap;
  assign all_on = (state_d_i == PS_FULL) || (state_d_i == PS_WAKE);
  assign doze   = (state_d_i == PS_DOZE);
  assign nap    = (state_d_i == PS_NAP);

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    logic en_d;
    if (g == UNIT_REFRESH) begin : g_ref
      assign en_d = 1'b1;
    end else if (g == UNIT_PCI_DEC) begin : g_dec
      assign en_d = all_on | doze;
    end else if (g == UNIT_BREQ_MON) begin : g_brq
      assign en_d = all_on | doze | nap;
    end else begin : g_gated
      assign en_d = all_on;
    end
    // registered so enables only move on an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) unit_en_o[g] <= 1'b1;
      else         unit_en_o[g] <= en_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned N_UNITS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_we_i,
  input  logic [1:0]         mode_i,
  input  logic               suspend_i,
  input  logic               pci_mem_hit_i,
  input  logic               bus_req_i,
  input  logic               access_done_i,
  output logic [N_UNITS-1:0] unit_en_o,
  output logic [2:0]         state_o
);
  logic [MODE_W-1:0] mode_q;
  pwr_state_e        state_q, state_d;

  pwr_mode_reg i_mode_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mode_we_i),
    .mode_i   (mode_i),
    .mode_q_o (mode_q)
  );

  pwr_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_q_i      (mode_q),
    .suspend_i     (suspend_i),
    .pci_mem_hit_i (pci_mem_hit_i),
    .bus_req_i     (bus_req_i),
    .access_done_i (access_done_i),
    .state_q_o     (state_q),
    .state_d_o     (state_d)
  );

  pwr_en_decode #(.N_UNITS(N_UNITS)) i_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .unit_en_o (unit_en_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_pkg::*;
#(
  parameter int unsigned N_UNITS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_we_i,
  input logic               suspend_i,
  input logic               pci_mem_hit_i,
  input logic               bus_req_i,
  input logic [N_UNITS-1:0] unit_en_o,
  input logic [2:0]         state_o
);
  localparam logic [N_UNITS-1:0] DOZE_MASK = N_UNITS'(3'b111);

  assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);
  assert_full_all_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(PS_FULL) || state_o == 3'(PS_WAKE)) |-> (&unit_en_o));
  assert_doze_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(PS_DOZE)) |-> (unit_en_o == DOZE_MASK));
  assert_refresh_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_en_o[UNIT_REFRESH]);
  assert_wake_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(PS_DOZE) && !suspend_i && (pci_mem_hit_i || bus_req_i))
      |=> (state_o == 3'(PS_WAKE)));
  assert_susp_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'(PS_SUSP) && suspend_i) |=> (state_o == 3'(PS_SUSP)));
  assert_susp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(PS_SUSP) && suspend_i) |=> (state_o == 3'(PS_SUSP)));
  assert_nap_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'(PS_NAP) && !suspend_i && !mode_we_i && !$past(mode_we_i))
      |=> (state_o == 3'(PS_NAP)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_UNITS(N_UNITS)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_we_i     (mode_we_i),
  .suspend_i     (suspend_i),
  .pci_mem_hit_i (pci_mem_hit_i),
  .bus_req_i     (bus_req_i),
  .unit_en_o     (unit_en_o),
  .state_o       (state_o)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int N = 8;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_we = 0, sus = 0, hit = 0, breq = 0, done = 0;
  logic [1:0] mode = 0;
  logic [N-1:0] en;
  logic [2:0] st_o;
  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";
  bit running = 1;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.N_UNITS(N)) i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we), .mode_i(mode),
    .suspend_i(sus), .pci_mem_hit_i(hit), .bus_req_i(breq),
    .access_done_i(done), .unit_en_o(en), .state_o(st_o));

  // reference model
  int m_st = 0, m_mq = 0, m_sv = 0;
  always @(posedge clk or negedge rst_ni) begin
    int nx;
    if (!rst_ni) begin
      m_st = 0; m_mq = 0; m_sv = 0;
    end else begin
      nx = m_st;
      if (m_st == 4) begin
        if (!sus) nx = m_sv;
      end else if (sus) begin
        m_sv = m_st; nx = 4;
      end else if (m_st == 1) begin
        if (hit || breq) nx = 5; else if (m_mq != 1) nx = m_mq;
      end else if (m_st == 5) begin
        if (m_mq == 0) nx = 0; else if (done) nx = m_mq;
      end else if (m_mq != m_st) nx = m_mq;
      if (mode_we) m_mq = int'(mode);
      m_st = nx;
    end
  end

  function automatic logic [N-1:0] exp_mask(int s);
    case (s)
      0, 5:    return '1;
      1:       return N'(8'h07);
      2:       return N'(8'h06);
      default: return N'(8'h02);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every cycle, well after the edge
  always @(posedge clk) if (running) begin
    #5;
    check({phase, " state"}, int'(st_o), m_st);
    check({phase, " enables"}, int'(en), int'(exp_mask(m_st)));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m);
    mode = m; mode_we = 1; cyc(1); mode_we = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && running) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R1 reset state", int'(st_o), 0);
    check("R1 reset enables", int'(en), int'(exp_mask(0)));
    rst_ni = 1;
    phase = "R3"; cyc(3);
    phase = "R2"; wr(2'd1); cyc(2);
    phase = "R4"; cyc(3);
    phase = "R6"; hit = 1; cyc(1); hit = 0;
    check("R6 wake on hit", int'(st_o), 5);
    phase = "R3"; cyc(3);
    phase = "R7"; done = 1; cyc(1); done = 0;
    check("R7 back to doze", int'(st_o), 1);
    phase = "R6"; breq = 1; cyc(1); breq = 0;
    check("R6 wake on breq", int'(st_o), 5);
    phase = "R8"; wr(2'd2); cyc(3);
    check("R8 deferred nap", int'(st_o), 5);
    done = 1; cyc(1); done = 0;
    check("R8 nap after done", int'(st_o), 2);
    phase = "R11"; hit = 1; breq = 1; cyc(4); hit = 0; breq = 0;
    check("R11 nap holds", int'(st_o), 2);
    phase = "R2"; wr(2'd3); cyc(2);
    check("R2 sleep", int'(st_o), 3);
    phase = "R11"; hit = 1; cyc(3); hit = 0;
    phase = "R2"; wr(2'd1); cyc(2);
    phase = "R8"; breq = 1; cyc(1); breq = 0; wr(2'd0); cyc(3);
    check("R8 full-on exit", int'(st_o), 0);
    phase = "R9"; sus = 1; cyc(2);
    check("R9 suspend", int'(st_o), 4);
    phase = "R10"; hit = 1; wr(2'd2); cyc(3); hit = 0;
    check("R10 suspend holds", int'(st_o), 4);
    phase = "R9"; sus = 0; cyc(1);
    check("R9 restore full", int'(st_o), 0);
    cyc(2);
    phase = "R2"; wr(2'd1); cyc(3);
    phase = "R10"; sus = 1; breq = 1; cyc(3); breq = 0;
    phase = "R9"; sus = 0; cyc(1);
    check("R9 restore doze", int'(st_o), 1);
    cyc(2);
    phase = "R1"; rst_ni = 0; #1;
    check("R1 async reset", int'(st_o), 0);
    cyc(2); rst_ni = 1; cyc(4);
    check("R1 mode cleared", int'(st_o), 0);
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule